// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is one SPI port that works either as the bus master or as a slave. A 13-bit control word selects the role, the clock idle level, the edge on which outgoing data moves, the master's input sample point, the transfer width (8 or 16 bits) and whether a slave honours its select line. The control word also holds two prescaler codes for the master clock and two bits that release the clock and data-out pins to general-purpose I/O.

A host places a word on `tx_data` and pulses `start`. `busy` stays high for the whole transfer. At the end a one-cycle `done` pulse marks the cycle in which `rx_data` takes the received word. Data moves most significant bit first. As master, the port makes the serial clock from `clk`. As slave, it follows an external clock through two-stage synchronizers, so the slave clock has to be much slower than `clk`. The control word must not change while `busy` is high.

Top module: `spi_port`

## Requirements
- R1: Control word layout: bit 0 master (1) or slave (0); bit 1 clock idle level; bit 2 data-change edge; bit 3 master sample point; bit 4 width (1 = 16 bits, 0 = 8 bits); bit 5 slave-select enable; bit 6 clock pin release; bit 7 data-out pin release; bits 9:8 first prescaler code; bits 12:10 second prescaler code.
- R2: When idle, `start` loads `tx_data` and raises `busy`. A `start` while `busy` is high is ignored. `done` is a single-cycle pulse, `busy` is low during it, and `rx_data` takes the received word in that same cycle.
- R3: In master mode each half-period of the serial clock lasts P·S cycles of `clk`. First prescaler codes 11/10/01/00 give P = 1/4/16/64. Second prescaler code c gives S = 8 − c. The forbidden pair P = 1, S = 1 is clamped to S = 2. `done` follows the `start` capture edge by exactly H·P·S cycles, where H is the number of half-periods.
- R4: The serial clock rests at the level of bit 1 whenever the master is idle. Its first edge in a transfer leaves that level.
- R5: With bit 2 = 1, outgoing data changes on active-to-idle clock edges and the first bit is driven before the first edge. With bit 2 = 0, it changes on idle-to-active edges. Bits go out MSB first.
- R6: In master mode, bit 3 = 0 samples input on the edge opposite to the change edge (mid-bit). Bit 3 = 1 samples at the next change point (end of bit). With bit 2 = 0 and bit 3 = 1, the transfer adds one half-period with no clock edge, so H = 2W + 1. Otherwise H = 2W.
- R7: In 8-bit transfers only `tx_data[7:0]` is sent, and `rx_data[15:8]` is zero.
- R8: In slave mode the port shifts on the external clock with the same edge rules and always samples mid-bit, whatever bit 3 holds.
- R9: In slave mode with bit 5 = 1, a high `ss_n` holds the bit counter cleared, blocks clock edges and drops `sdo_oe`. With bit 5 = 0, `ss_n` has no effect.
- R10: Bit 6 drops `sck_oe` in master mode, and bit 7 drops `sdo_oe` in both modes. Otherwise the master drives both pins.
- R11: After reset `busy`, `done` and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 13 | Control word (R1) |
| tx_data | input | 16 | Word to send |
| start | input | 1 | Begin or arm a transfer |
| rx_data | output | 16 | Last received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Clock pin output enable |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out pin output enable |

## Verification
In master mode edge k of a transfer lands exactly k·P·S cycles after the edge that captures `start`, and `done` lands H·P·S cycles after it. The bench counts cycles from that capture edge. It sets `sdi` and reads `sdo` and `sck_o` on the falling edge just before each computed edge. It also compares the arrival of `done` with H·P·S. The bench drives `sdi` with the pattern only around the mid-bit point and inverted at the end-bit point, so the received word shows which sample point was used. In slave mode the port responds two to three cycles after each external edge, so the bench holds every half-period for eight cycles and reads `sdo`, `done` and `rx_data` well after that delay.

// File: rtl/spi_port.sv
module spi_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] ctrl,
  input  logic [15:0] tx_data,
  input  logic        start,
  output logic [15:0] rx_data,
  output logic        busy,
  output logic        done,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        ss_n,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_oe
);

  wire master  = ctrl[0];
  wire cpol    = ctrl[1];
  wire cke     = ctrl[2];
  wire smp     = ctrl[3];
  wire wide    = ctrl[4];
  wire ss_en   = ctrl[5];
  wire sck_off = ctrl[6];
  wire sdo_off = ctrl[7];

  wire [9:0] pre_p = (ctrl[9:8] == 2'b11) ? 10'd1  :
                     (ctrl[9:8] == 2'b10) ? 10'd4  :
                     (ctrl[9:8] == 2'b01) ? 10'd16 : 10'd64;
  wire [9:0] pre_s_raw = 10'd8 - {7'd0, ctrl[12:10]};
  wire [9:0] pre_s = (pre_p == 10'd1 && pre_s_raw == 10'd1) ? 10'd2 : pre_s_raw;
  wire [9:0] half_len = pre_p * pre_s;

  wire [4:0] nbits = wide ? 5'd16 : 5'd8;
  wire [5:0] nedge = {nbits, 1'b0};
  wire [5:0] nhalf = nedge + {5'd0, ~cke & smp};

  logic        run, sck_a;
  logic [9:0]  dcnt;
  logic [5:0]  kc;
  logic [4:0]  bcnt;
  logic [15:0] tsr, rsr;
  logic [2:0]  s_sck;
  logic [1:0]  s_ss, s_sdi;

  wire [5:0]  kn      = kc + 6'd1;
  wire [4:0]  bn      = bcnt + 5'd1;
  wire        bit_in  = master ? sdi : s_sdi[1];
  wire [15:0] rsr_nx  = {rsr[14:0], bit_in};
  wire        m_samp  = (kn[0] == (cke ^ smp));
  wire        m_shift = (kn[0] != cke) && (kn >= 6'd2) && (kn < nedge);
  wire        act_now = s_sck[1] ^ cpol;
  wire        act_old = s_sck[2] ^ cpol;
  wire        s_lead  = act_now & ~act_old;
  wire        s_trail = ~act_now & act_old;
  wire        s_sel   = ~ss_en | ~s_ss[1];
  wire        s_samp  = cke ? s_lead : s_trail;
  wire        s_shift = cke ? s_trail : s_lead;
  wire [15:0] tx_load = wide ? tx_data : {tx_data[7:0], 8'h00};

  function automatic logic [15:0] fit(input logic [15:0] v, input logic w);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; sck_a <= 1'b0; dcnt <= '0; kc <= '0; bcnt <= '0;
      tsr <= '0; rsr <= '0; rx_data <= '0; busy <= 1'b0; done <= 1'b0;
      s_sck <= '0; s_ss <= 2'b11; s_sdi <= '0;
    end else begin
      done  <= 1'b0;
      s_sck <= {s_sck[1:0], sck_i};
      s_ss  <= {s_ss[0], ss_n};
      s_sdi <= {s_sdi[0], sdi};
      if (start && !busy) begin
        tsr  <= tx_load;
        busy <= 1'b1;
        bcnt <= '0;
        if (master) begin
          run   <= 1'b1;
          dcnt  <= half_len - 10'd1;
          kc    <= '0;
          sck_a <= 1'b0;
        end
      end else if (master) begin
        if (run) begin
          if (dcnt != 10'd0) begin
            dcnt <= dcnt - 10'd1;
          end else begin
            dcnt <= half_len - 10'd1;
            kc   <= kn;
            if (kn <= nedge) sck_a <= ~sck_a;
            if (m_samp)      rsr <= rsr_nx;
            if (m_shift)     tsr <= {tsr[14:0], 1'b0};
            if (kn == nhalf) begin
              run     <= 1'b0;
              busy    <= 1'b0;
              done    <= 1'b1;
              rx_data <= fit(m_samp ? rsr_nx : rsr, wide);
            end
          end
        end
      end else if (!s_sel) begin
        bcnt <= '0;
      end else if (s_samp) begin
        rsr <= rsr_nx;
        if (bn == nbits) begin
          bcnt    <= '0;
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_data <= fit(rsr_nx, wide);
        end else begin
          bcnt <= bn;
        end
      end else if (s_shift && bcnt != 5'd0) begin
        tsr <= {tsr[14:0], 1'b0};
      end
    end
  end

  assign sck_o  = cpol ^ sck_a;
  assign sck_oe = master & ~sck_off;
  assign sdo    = tsr[15];
  assign sdo_oe = ~sdo_off & (master | s_sel);

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] ctrl,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [15:0] rx_data,
  input logic        sck_o,
  input logic        ss_n,
  input logic        sdo_oe
);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !busy) |-> (sck_o == ctrl[1]));

  p_narrow_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl[4]) |-> (rx_data[15:8] == 8'h00));

  p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && ctrl[5] && ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !sdo_oe);

endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .start(start), .busy(busy),
  .done(done), .rx_data(rx_data), .sck_o(sck_o), .ss_n(ss_n), .sdo_oe(sdo_oe)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] ctrl = '0;
  logic [15:0] tx_data = '0;
  logic        start = 1'b0;
  logic [15:0] rx_data;
  logic        busy, done;
  logic        sck_i = 1'b0;
  logic        sck_o, sck_oe;
  logic        ss_n = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  logic [15:0] last_rx = '0;

  always #5 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tx_data(tx_data), .start(start),
    .rx_data(rx_data), .busy(busy), .done(done), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always @(posedge clk) if (done) begin
    done_cnt <= done_cnt + 1;
    last_rx  <= rx_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(input bit m, cpol, cke, smp, w16, ssen, sckoff, sdooff,
                                     input logic [1:0] pp, input logic [2:0] sp);
    return {sp, pp, sdooff, sckoff, ssen, w16, smp, cke, cpol, m};
  endfunction

  function automatic int half_of(input logic [12:0] cw);
    int p, s;
    case (cw[9:8])
      2'b11: p = 1;
      2'b10: p = 4;
      2'b01: p = 16;
      default: p = 64;
    endcase
    s = 8 - int'(cw[12:10]);
    if (p == 1 && s == 1) s = 2;
    return p * s;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    chk(done == 1'b0, "R11 done after reset", done, 0);
    chk(rx_data == 16'h0, "R11 rx_data after reset", rx_data, 0);
  endtask

  task automatic t_master(input logic [12:0] cw, input logic [15:0] tx, input logic [15:0] pat, input string tag);
    int w, n, h, c, k, j;
    bit cke, cpol, smp, sck_ok, busy_ok;
    logic [15:0] got, exp_rx, mask;
    w = cw[4] ? 16 : 8;
    cke = cw[2]; cpol = cw[1]; smp = cw[3];
    n = half_of(cw);
    h = 2 * w + ((!cke && smp) ? 1 : 0);
    mask = (w == 16) ? 16'hFFFF : 16'h00FF;
    exp_rx = (smp ? ~pat : pat) & mask;
    got = '0; sck_ok = 1; busy_ok = 1;
    ctrl = cw; tx_data = tx;
    repeat (3) @(negedge clk);
    chk(sck_o == cpol, {tag, " R4 idle clock level"}, sck_o, cpol);
    start = 1'b1;
    @(posedge clk);
    c = 0;
    forever begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (c == 5) begin start = 1'b1; tx_data = ~tx; end
      if (c == 6) start = 1'b0;
      if (done || c > 20000) break;
      if (!busy) busy_ok = 0;
      if ((c + 1) % n == 0) begin
        k = (c + 1) / n;
        if (k <= 2 * w && sck_o != (cpol ^ ((k - 1) % 2 == 1))) sck_ok = 0;
        if ((k % 2) == (cke ? 1 : 0)) begin
          j = cke ? (k - 1) / 2 : k / 2 - 1;
          if (j < w) begin
            sdi = pat[w - 1 - j];
            got[w - 1 - j] = sdo;
          end
        end else begin
          j = cke ? k / 2 - 1 : (k - 3) / 2;
          if (k >= 2 && (cke || k >= 3) && j < w) sdi = ~pat[w - 1 - j];
          else sdi = 1'b0;
        end
      end
      @(posedge clk);
      c++;
    end
    chk(c == h * n, {tag, " R3 R6 done arrival cycle"}, c, h * n);
    chk(rx_data == exp_rx, {tag, " R6 R7 received word"}, rx_data, exp_rx);
    chk(got == (tx & mask), {tag, " R5 R2 bits sent MSB first, restart ignored"}, got, tx & mask);
    chk(sck_ok, {tag, " R4 R5 clock level before each edge"}, sck_ok, 1);
    chk(busy_ok, {tag, " R2 busy held during transfer"}, busy_ok, 1);
    @(negedge clk);
    chk(!done && sck_o == cpol, {tag, " R2 R4 done single cycle, clock back idle"}, {done, sck_o}, {1'b0, cpol});
  endtask

  task automatic sl_bits(input bit cke, input bit cpol, input int n, input int w,
                         input logic [15:0] pat, output logic [15:0] got);
    got = '0;
    for (int j = 0; j < n; j++) begin
      if (cke) begin
        sdi = pat[w - 1 - j];
        repeat (HP) @(negedge clk);
        got[w - 1 - j] = sdo;
        sck_i = ~cpol;
        repeat (HP) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        sdi = pat[w - 1 - j];
        repeat (HP) @(negedge clk);
        got[w - 1 - j] = sdo;
        sck_i = cpol;
        repeat (HP) @(negedge clk);
      end
    end
    repeat (HP) @(negedge clk);
  endtask

  task automatic t_slave(input logic [12:0] cw, input logic [15:0] tx, input logic [15:0] pat,
                         input logic ssv, input string tag);
    int w, d0;
    logic [15:0] got, mask;
    w = cw[4] ? 16 : 8;
    mask = (w == 16) ? 16'hFFFF : 16'h00FF;
    ctrl = cw; sck_i = cw[1]; ss_n = ssv;
    repeat (6) @(negedge clk);
    tx_data = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    d0 = done_cnt;
    sl_bits(cw[2], cw[1], w, w, pat, got);
    chk(done_cnt == d0 + 1 && !busy, {tag, " R8 R2 one done, busy dropped"}, done_cnt - d0, 1);
    chk(last_rx == (pat & mask), {tag, " R8 slave received word"}, last_rx, pat & mask);
    chk(got == (tx & mask), {tag, " R5 R8 slave bits sent"}, got, tx & mask);
  endtask

  task automatic t_select;
    int d0;
    logic [15:0] got;
    ctrl = mk(0, 0, 1, 0, 0, 1, 0, 0, 2'b11, 3'b101);
    sck_i = 1'b0; ss_n = 1'b1;
    repeat (6) @(negedge clk);
    tx_data = 16'h005A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0, "R9 sdo released while deselected", sdo_oe, 0);
    d0 = done_cnt;
    sl_bits(1'b1, 1'b0, 8, 8, 16'h00FF, got);
    chk(done_cnt == d0, "R9 clock ignored while deselected", done_cnt - d0, 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    sl_bits(1'b1, 1'b0, 3, 8, 16'h00FF, got);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b1, "R9 sdo driven while selected", sdo_oe, 1);
    sl_bits(1'b1, 1'b0, 8, 8, 16'h0093, got);
    chk(done_cnt == d0 + 1 && last_rx == 16'h0093, "R9 bit counter cleared by deselect",
        last_rx, 16'h0093);
  endtask

  task automatic t_pins;
    ctrl = mk(1, 0, 1, 0, 0, 0, 0, 0, 2'b11, 3'b101);
    repeat (2) @(negedge clk);
    chk(sck_oe && sdo_oe, "R10 master drives both pins", {sck_oe, sdo_oe}, 2'b11);
    ctrl = mk(1, 0, 1, 0, 0, 0, 1, 1, 2'b11, 3'b101);
    repeat (2) @(negedge clk);
    chk(!sck_oe, "R10 clock pin released", sck_oe, 0);
    chk(!sdo_oe, "R10 data-out pin released in master", sdo_oe, 0);
    ctrl = mk(0, 0, 1, 0, 0, 0, 0, 1, 2'b11, 3'b101);
    repeat (2) @(negedge clk);
    chk(!sdo_oe && !sck_oe, "R10 data-out pin released in slave", {sck_oe, sdo_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_master(mk(1, 0, 1, 0, 0, 0, 0, 0, 2'b11, 3'b101), 16'h00A5, 16'h003C, "A R1");
    t_master(mk(1, 1, 0, 0, 1, 0, 0, 0, 2'b10, 3'b110), 16'hBEEF, 16'h1234, "B");
    t_master(mk(1, 1, 1, 1, 0, 0, 0, 0, 2'b11, 3'b111), 16'h00C3, 16'h0069, "C clamp");
    t_master(mk(1, 0, 0, 1, 1, 0, 0, 0, 2'b11, 3'b101), 16'h8E71, 16'hA5F0, "D");
    t_master(mk(1, 0, 1, 0, 0, 0, 0, 0, 2'b00, 3'b000), 16'h0017, 16'h00E8, "E slowest");
    t_slave(mk(0, 0, 1, 0, 0, 0, 0, 0, 2'b11, 3'b101), 16'h00B6, 16'h004D, 1'b1, "S1 ss ignored");
    t_slave(mk(0, 1, 0, 1, 1, 0, 0, 0, 2'b11, 3'b101), 16'hC0DE, 16'h5AA3, 1'b0, "S2 smp forced");
    t_slave(mk(0, 1, 1, 0, 1, 1, 0, 0, 2'b11, 3'b101), 16'h1F2E, 16'h9876, 1'b0, "S3");
    t_select();
    t_pins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule